// File: doc/BRIEF.md
# SEC-DED Check-Bit Encoder

This block computes the check bits of an extended Hamming code for a data word of configurable width. Check bits are meant to be stored or sent next to the unchanged data. A matching decoder can then correct any single flipped bit and flag any two flipped bits. The block is purely combinational: the check-bit vector follows the data input with no clock and no state.

Inside the block, the data bits are laid out on an imaginary codeword. Positions are numbered from 1. The power-of-two slots are reserved for Hamming parity bits, and the data bits fill the other slots in ascending order. Each Hamming bit is the parity of the data positions whose index has the matching bit set. One further bit, placed at the top of the output, gives the parity of the whole word. A parameter chooses even or odd polarity for every check bit.

Top module: `secded_encoder`

## Requirements
- R1: The check-bit output is $clog2(DATA_W)+2 bits wide: 5 bits for DATA_W=8, 7 bits for 32 and 8 bits for 64. DATA_W must be a power of two of at least 8.
- R2: Data bit j sits at codeword position p_j. p_j is the (j+1)-th integer of 3 or more that is not a power of two, so bit 0 is at 3, bit 1 at 5, bit 4 at 9 and bit 31 at 38. In even mode, a data word with only bit j set gives Hamming bits ecc_o[R-2:0] equal to p_j.
- R3: In even mode, Hamming bit i (ecc_o[i], for i < R-1) is the XOR of every data bit whose position p_j has bit i set. For any data word, the Hamming bits therefore equal the XOR of p_j over all set data bits.
- R4: The most significant output bit is the overall parity bit. In even mode, the count of ones across data_i and all of ecc_o is even.
- R5: In odd mode (ODD_PAR=1), each Hamming bit is the inverse of its even-mode value. The count of ones across data_i and all of ecc_o is then odd.
- R6: An all-zero data word gives ecc_o = 0 in even mode. In odd mode it gives all Hamming bits set, with the overall bit equal to 1 XOR the parity of R-1.
- R7: The output is a combinational function of data_i alone. A change of data_i between clock edges is reflected on ecc_o without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Data word to protect |
| ecc_o | output | $clog2(DATA_W)+2 | Hamming bits in the low part, overall parity bit in the MSB |

## Verification
The bench builds three copies of the block. The default copy uses a 32-bit word with even polarity. A second copy uses an 8-bit word with odd polarity, and a third uses a 64-bit word with even polarity. Together they reach all three check-bit widths and both polarities, and they cover the odd-mode overall bit when R-1 is even. The 64-bit copy places data bits at codeword positions up to 71, which exercises the top Hamming bit. Walking-one words tie every data index to its codeword position. Mixed and pseudo-random words exercise the XOR sums and the parity of the whole word.

// File: rtl/secded_enc_pkg.sv
package secded_enc_pkg;

  function automatic int unsigned chk_bits(input int unsigned w);
    return $clog2(w) + 2;
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // codeword slots 1..cw_len hold ham bits plus data
  function automatic int unsigned cw_len(input int unsigned w);
    return w + chk_bits(w) - 1;
  endfunction

  // position of data bit j: (j+1)-th non power of two from 3
  function automatic int unsigned data_pos(input int unsigned j);
    int unsigned k;
    k = 0;
    for (int unsigned c = 3; c < 4096; c++) begin
      if (!is_pow2(c)) begin
        if (k == j) return c;
        k++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/secded_scatter.sv
module secded_scatter
  import secded_enc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HAM_W  = 6,
  localparam int unsigned CW_LEN = DATA_W + HAM_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_LEN:1]   cw_o
);

  for (genvar j = 0; j < DATA_W; j++) begin : g_data
    assign cw_o[data_pos(j)] = data_i[j];
  end

  // check slots carry no data
  for (genvar i = 0; i < HAM_W; i++) begin : g_hole
    assign cw_o[1 << i] = 1'b0;
  end

endmodule

// File: rtl/secded_ham_gen.sv
module secded_ham_gen #(
  parameter int unsigned CW_LEN  = 38,
  parameter int unsigned HAM_W   = 6,
  parameter bit          ODD_PAR = 1'b0
) (
  input  logic [CW_LEN:1]  cw_i,
  output logic [HAM_W-1:0] ham_o
);

  for (genvar i = 0; i < HAM_W; i++) begin : g_bit
    always_comb begin
      logic acc;
      acc = ODD_PAR;
      for (int p = 1; p <= CW_LEN; p++) begin
        if (((p >> i) & 1) == 1) acc = acc ^ cw_i[p];
      end
      ham_o[i] = acc;
    end
  end

endmodule

// File: rtl/secded_overall_gen.sv
module secded_overall_gen #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HAM_W   = 6,
  parameter bit          ODD_PAR = 1'b0
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W-1:0]  ham_i,
  output logic              par_o
);

  logic data_par;
  logic ham_par;

  assign data_par = ^data_i;
  assign ham_par  = ^ham_i;
  assign par_o    = data_par ^ ham_par ^ ODD_PAR;

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_enc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          ODD_PAR = 1'b0,
  localparam int unsigned ECC_W  = chk_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc_o
);

  localparam int unsigned HAM_W  = ECC_W - 1;
  localparam int unsigned CW_LEN = DATA_W + HAM_W;

  if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_width
    $error("secded_encoder: DATA_W must be a power of two >= 8");
  end

  logic [CW_LEN:1]  cw;
  logic [HAM_W-1:0] ham;
  logic             overall;

  secded_scatter #(
    .DATA_W(DATA_W),
    .HAM_W (HAM_W)
  ) u_scatter (
    .data_i(data_i),
    .cw_o  (cw)
  );

  secded_ham_gen #(
    .CW_LEN (CW_LEN),
    .HAM_W  (HAM_W),
    .ODD_PAR(ODD_PAR)
  ) u_ham (
    .cw_i (cw),
    .ham_o(ham)
  );

  secded_overall_gen #(
    .DATA_W (DATA_W),
    .HAM_W  (HAM_W),
    .ODD_PAR(ODD_PAR)
  ) u_overall (
    .data_i(data_i),
    .ham_i (ham),
    .par_o (overall)
  );

  assign ecc_o = {overall, ham};

endmodule

// File: rtl/secded_encoder_chk.sv
module secded_encoder_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          ODD_PAR = 1'b0,
  parameter int unsigned ECC_W   = 7
) (
  input logic [DATA_W-1:0] data_i,
  input logic [ECC_W-1:0]  ecc_o
);

  localparam int unsigned HAM_W = ECC_W - 1;
  localparam logic [HAM_W-1:0] HAM_MASK = ODD_PAR ? '1 : '0;
  localparam logic ZERO_TOP = ODD_PAR ? (1'b1 ^ HAM_W[0]) : 1'b0;

  always_comb begin
    if (!$isunknown(data_i)) begin
      assert_known_R7 : assert (!$isunknown(ecc_o));
      assert_word_parity_R4 : assert ((^{data_i, ecc_o}) == ODD_PAR);
      if (data_i == '0) begin
        assert_zero_word_R6 : assert (ecc_o == {ZERO_TOP, HAM_MASK});
      end
      if ($onehot(data_i)) begin
        // a data slot is never a power of two
        assert_data_slot_R2 : assert ($countones(ecc_o[HAM_W-1:0] ^ HAM_MASK) >= 2);
      end
    end
  end

endmodule

bind secded_encoder secded_encoder_chk #(
  .DATA_W (DATA_W),
  .ODD_PAR(ODD_PAR),
  .ECC_W  (ECC_W)
) u_chk (
  .data_i(data_i),
  .ecc_o (ecc_o)
);

// File: tb/secded_encoder_tb.sv
`timescale 1ns/1ps
module secded_encoder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] din = '0;
  logic [31:0] d32;
  logic [7:0]  d8;
  logic [6:0]  e32;
  logic [4:0]  e8;
  logic [7:0]  e64;

  assign d32 = din[31:0];
  assign d8  = din[7:0];

  secded_encoder #(.DATA_W(32), .ODD_PAR(1'b0)) u_dut   (.data_i(d32), .ecc_o(e32));
  secded_encoder #(.DATA_W(8),  .ODD_PAR(1'b1)) u_dut_b (.data_i(d8),  .ecc_o(e8));
  secded_encoder #(.DATA_W(64), .ODD_PAR(1'b0)) u_dut_c (.data_i(din), .ecc_o(e64));

  typedef struct {
    logic [63:0] d;
    logic [7:0]  x32;
    logic [7:0]  x8;
    logic [7:0]  x64;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] ref_ecc(input logic [63:0] d, input int w, input bit odd);
    int r;
    int syn;
    int idx;
    logic [7:0]  hmask;
    logic [7:0]  ham;
    logic [63:0] dmask;
    logic        ov;
    r = $clog2(w) + 2;
    syn = 0;
    idx = 0;
    for (int p = 3; idx < w; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[idx]) syn = syn ^ p;
        idx++;
      end
    end
    hmask = (8'd1 << (r - 1)) - 8'd1;
    ham = 8'(syn) & hmask;
    if (odd) ham = ham ^ hmask;
    dmask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    ov = odd ^ (^(d & dmask)) ^ (^ham);
    return ham | (8'(ov) << (r - 1));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] v, input string tag);
    item_t it;
    @(posedge clk);
    din = v;
    it.d   = v;
    it.x32 = ref_ecc(v, 32, 1'b0);
    it.x8  = ref_ecc(v, 8, 1'b1);
    it.x64 = ref_ecc(v, 64, 1'b0);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " w32"}, 64'(e32), 64'(it.x32[6:0]));
        check({it.tag, " w64"}, 64'(e64), 64'(it.x64));
        check("R5 w8 odd", 64'(e8), 64'(it.x8[4:0]));
        check("R4 w32 parity", 64'(^{d32, e32}), 64'd0);
        check("R5 w8 parity", 64'(^{d8, e8}), 64'd1);
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 widths
    check("R1 w8", 64'($bits(u_dut_b.ecc_o)), 64'd5);
    check("R1 w32", 64'($bits(u_dut.ecc_o)), 64'd7);
    check("R1 w64", 64'($bits(u_dut_c.ecc_o)), 64'd8);
    // R6 zero word, reset state of the stimulus
    send(64'd0, "R6");
    // R2 walking ones
    for (int j = 0; j < 64; j++) send(64'd1 << j, "R2");
    // R3 mixed words
    send('1, "R3");
    send(64'hA5A5_A5A5_5A5A_5A5A, "R3");
    send(64'h0123_4567_89AB_CDEF, "R3");
    send(64'h8000_0000_0000_0001, "R3");
    s = 64'h1357_9BDF_2468_ACE0;
    for (int k = 0; k < 40; k++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 7);
      s = s ^ (s << 17);
      send(s, "R3");
    end
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    // R7 change between edges, sampled before the next edge
    @(negedge clk);
    din = 64'h0000_0000_DEAD_BEEF;
    #1;
    check("R7 w32", 64'(e32), 64'(ref_ecc(din, 32, 1'b0) & 8'h7F));
    check("R7 w8", 64'(e8), 64'(ref_ecc(din, 8, 1'b1) & 8'h1F));
    din = 64'd0;
    #0.5;
    check("R7 w32 zero", 64'(e32), 64'd0);
    check("R6 w8 odd zero", 64'(e8), 64'h1F);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule